// File: doc/BRIEF.md
# Broadcast 4x4 Halfword Matrix Multiplier

This block multiplies two 4x4 matrices of 32-bit words. One 16-bit half of each word takes part, chosen separately for the left and the right operand. The block is an array of sixteen processing elements laid out in four rows and four columns. Each element owns one result position and keeps a 40-bit signed accumulator for it.

A start strobe captures both operand matrices, the halfword-select code and the accumulate flag. Over the next four cycles a sequencer steps an index k from 0 to 3. In step k, column k of the left matrix drives one value on each row bus, and row k of the right matrix drives one value on each column bus. Every element multiplies the two values it receives as signed numbers and adds the product into its accumulator. After the fourth addition the block raises a one-cycle done strobe. The low 32 bits of all sixteen accumulators are always visible on a parallel readback port.

In overwrite mode the accumulators start from zero. In accumulate mode the new sum is added to whatever the accumulators already hold, so a larger matrix product can be built from a chain of 4x4 block products.

Top module: `bmm_engine`

## Requirements
- R1: Packing: element (r,c) of any matrix port sits at bits [(r*4+c)*32 +: 32]. After an operation, accumulator (i,j) holds the sum over k=0..3 of A(i,k)*B(k,j), using the selected halfwords.
- R2: hsel_i[1] picks the half of A and hsel_i[0] picks the half of B. A value of 1 selects bits [31:16] and a value of 0 selects bits [15:0]. Each bit acts independently of the other.
- R3: Halfwords are two's-complement signed, and their 32-bit products are sign-extended into the 40-bit accumulators.
- R4: A start accepted at clock edge E produces a done_o pulse exactly one cycle wide, in the cycle after edge E+4. The final results are on acc_o in that same cycle.
- R5: With accum_i = 0 at start, the previous accumulator contents are discarded and the result is the new sum alone.
- R6: With accum_i = 1 at start, the new sum is added to the previous 40-bit accumulator contents.
- R7: A start_i arriving during the four busy cycles is ignored. It causes no extra done pulse and no change to the running result. A start in the cycle where done_o is high is accepted.
- R8: acc_o carries the low 32 bits of each 40-bit accumulator. Bits above 31 are kept internally and take part in later accumulation.
- R9: After reset, every accumulator reads zero and done_o is low.
- R10: Operands, hsel_i and accum_i are captured at the start edge. Changes to them during the operation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| a_mat_i | input | 512 | Left operand matrix, 16 words |
| b_mat_i | input | 512 | Right operand matrix, 16 words |
| hsel_i | input | 2 | Halfword select: bit 1 for A, bit 0 for B, 1 = high half |
| accum_i | input | 1 | 1 = add to the accumulators, 0 = overwrite them |
| done_o | output | 1 | One-cycle pulse when the results are final |
| acc_o | output | 512 | Low 32 bits of the 16 accumulators |

## Verification
For each accepted start, the driver records the cycle in which done_o is due: five counter ticks after the negative edge on which start_i was raised, which is four cycles after the start edge. The driver also pushes the expected 16 words, taken from a 40-bit reference model kept in the bench. The monitor samples on falling edges. Whenever done_o is high, it compares the current cycle with the recorded due cycle and compares all sixteen readback words. A done pulse with nothing queued counts as a miscompare, and this is how an ignored start that was wrongly accepted gets caught.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int unsigned DIM  = 4;
  localparam int unsigned WORD = 32;
  localparam int unsigned HALF = 16;
  localparam int unsigned ACCW = 40;
  localparam int unsigned NELM = DIM * DIM;
  localparam int unsigned KW   = $clog2(DIM);

  typedef logic [HALF-1:0] half_t;
  typedef logic [ACCW-1:0] acc_t;

  function automatic half_t pick_half(input logic [WORD-1:0] w, input logic hi);
    return hi ? w[WORD-1:HALF] : w[HALF-1:0];
  endfunction
endpackage

// File: rtl/bmm_seq.sv
module bmm_seq #(
  parameter int unsigned DIM = bmm_pkg::DIM,
  localparam int unsigned KW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          first_o,
  output logic [KW-1:0] k_o,
  output logic          done_o
);
  localparam logic [KW-1:0] KLAST = KW'(DIM - 1);

  logic          busy_q, done_q;
  logic [KW-1:0] k_q;
  logic          last;

  assign last   = busy_q && (k_q == KLAST);
  assign load_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load_o) begin
        busy_q <= 1'b1;
        k_q    <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          k_q    <= '0;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign first_o = busy_q && (k_q == '0);
  assign k_o     = k_q;
  assign done_o  = done_q;

  // R4: single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R4: done follows the last step
  a_r4_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && k_q == KLAST) |=> done_q);
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  // R7: a start while busy never restarts the step index
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && k_q != KLAST) |=> (busy_q && k_q != '0));
endmodule

// File: rtl/bmm_opnd.sv
module bmm_opnd
  import bmm_pkg::*;
#(
  parameter int unsigned DIM = bmm_pkg::DIM,
  localparam int unsigned KW = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int unsigned MW = DIM * DIM * WORD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     busy_i,
  input  logic [MW-1:0]            a_mat_i,
  input  logic [MW-1:0]            b_mat_i,
  input  logic [1:0]               hsel_i,
  input  logic                     accum_i,
  input  logic [KW-1:0]            k_i,
  output logic                     accum_o,
  output logic [DIM-1:0][HALF-1:0] row_bus_o,
  output logic [DIM-1:0][HALF-1:0] col_bus_o
);
  logic [MW-1:0] a_q, b_q;
  logic [1:0]    hsel_q;
  logic          accum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      hsel_q  <= '0;
      accum_q <= 1'b0;
    end else if (load_i) begin
      a_q     <= a_mat_i;
      b_q     <= b_mat_i;
      hsel_q  <= hsel_i;
      accum_q <= accum_i;
    end
  end

  // Row r carries A(r,k); column c carries B(k,c)
  for (genvar g = 0; g < DIM; g++) begin : g_bus
    logic [WORD-1:0] a_word, b_word;
    always_comb begin
      a_word = a_q[(g*DIM + int'(k_i))*WORD +: WORD];
      b_word = b_q[(int'(k_i)*DIM + g)*WORD +: WORD];
    end
    assign row_bus_o[g] = pick_half(a_word, hsel_q[1]);
    assign col_bus_o[g] = pick_half(b_word, hsel_q[0]);
  end

  assign accum_o = accum_q;

  // R10: captured operands hold through the operation
  a_r10_operands_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !load_i) |=> ($stable(a_q) && $stable(b_q) && $stable(hsel_q) && $stable(accum_q)));
endmodule

// File: rtl/bmm_pe.sv
module bmm_pe
  import bmm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            first_i,
  input  logic            accum_i,
  input  logic [HALF-1:0] row_i,
  input  logic [HALF-1:0] col_i,
  output logic [ACCW-1:0] acc_o
);
  logic signed [2*HALF-1:0] prod;
  logic        [ACCW-1:0]   prod_ext, base, acc_q;

  assign prod     = $signed(row_i) * $signed(col_i);
  assign prod_ext = {{(ACCW-2*HALF){prod[2*HALF-1]}}, prod};
  assign base     = (first_i && !accum_i) ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= base + prod_ext;
  end

  assign acc_o = acc_q;

  // R1: accumulator changes only during active steps
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
  // R5, R3: overwrite start leaves exactly the sign-extended first product
  a_r5_overwrite_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && first_i && !accum_i) |=>
      ($signed(acc_q) == ACCW'($signed($past(row_i)) * $signed($past(col_i)))));
endmodule

// File: rtl/bmm_engine.sv
module bmm_engine
  import bmm_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NELM*WORD-1:0]  a_mat_i,
  input  logic [NELM*WORD-1:0]  b_mat_i,
  input  logic [1:0]            hsel_i,
  input  logic                  accum_i,
  output logic                  done_o,
  output logic [NELM*WORD-1:0]  acc_o
);
  logic                     load, busy, first, accum;
  logic [KW-1:0]            k;
  logic [DIM-1:0][HALF-1:0] row_bus, col_bus;

  bmm_seq #(.DIM(DIM)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy),
    .first_o (first),
    .k_o     (k),
    .done_o  (done_o)
  );

  bmm_opnd #(.DIM(DIM)) u_opnd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .busy_i    (busy),
    .a_mat_i   (a_mat_i),
    .b_mat_i   (b_mat_i),
    .hsel_i    (hsel_i),
    .accum_i   (accum_i),
    .k_i       (k),
    .accum_o   (accum),
    .row_bus_o (row_bus),
    .col_bus_o (col_bus)
  );

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      logic [ACCW-1:0] acc;
      bmm_pe u_pe (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (busy),
        .first_i (first),
        .accum_i (accum),
        .row_i   (row_bus[r]),
        .col_i   (col_bus[c]),
        .acc_o   (acc)
      );
      assign acc_o[(r*DIM + c)*WORD +: WORD] = acc[WORD-1:0];
    end
  end

  // R9: no done while the result is still being formed
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !done_o);
endmodule

// File: tb/bmm_engine_test.sv
module bmm_engine_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [511:0] a_mat_i = '0;
  logic [511:0] b_mat_i = '0;
  logic [1:0]   hsel_i = '0;
  logic         accum_i = 1'b0;
  logic         done_o;
  logic [511:0] acc_o;

  bmm_engine uut (.*);

  always #5 clk_i = ~clk_i;

  int unsigned cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  logic [39:0]  model [16];
  logic [511:0] exp_q [$];
  int unsigned  due_q [$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] el(input logic [511:0] m, input int r, input int c);
    return m[(r*4+c)*32 +: 32];
  endfunction

  // Driver: model update, queue push, start pulse, then scramble inputs (R10)
  task automatic run(input logic [511:0] a, input logic [511:0] b,
                     input logic [1:0] hs, input logic acc);
    logic [511:0] e;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [39:0] s;
        s = acc ? model[i*4+j] : 40'd0;
        for (int k = 0; k < 4; k++) begin
          logic signed [15:0] ha, hb;
          longint p;
          ha = hs[1] ? el(a,i,k)[31:16] : el(a,i,k)[15:0];
          hb = hs[0] ? el(b,k,j)[31:16] : el(b,k,j)[15:0];
          p  = ha * hb;
          s  = s + 40'(p);
        end
        model[i*4+j] = s;
        e[(i*4+j)*32 +: 32] = s[31:0];
      end
    end
    @(negedge clk_i);
    exp_q.push_back(e);
    due_q.push_back(cyc + 5);
    start_i = 1'b1; a_mat_i = a; b_mat_i = b; hsel_i = hs; accum_i = acc;
    @(negedge clk_i);
    start_i = 1'b0; a_mat_i = ~a; b_mat_i = {b[255:0], b[511:256]};
    hsel_i = ~hs; accum_i = ~acc;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // Monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 64'd1, 64'd0);
      end else begin
        logic [511:0] e;
        int unsigned d;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        check("R4 done cycle", 64'(cyc), 64'(d));
        for (int w = 0; w < 16; w++)
          check("R1 R8 result word", 64'(acc_o[w*32 +: 32]), 64'(e[w*32 +: 32]));
      end
    end
  end

  function automatic logic [511:0] fill(input int base, input int step);
    logic [511:0] m;
    for (int w = 0; w < 16; w++) m[w*32 +: 32] = 32'(base + step*w);
    return m;
  endfunction

  function automatic logic [511:0] rnd();
    logic [511:0] m;
    for (int w = 0; w < 16; w++) m[w*32 +: 32] = $urandom;
    return m;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    #200000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] a, b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset acc", 64'(acc_o == '0), 64'd1);
    check("R9 reset done", 64'(done_o), 64'd0);

    // R1: small positives, low halves
    run(fill(1, 1), fill(2, 3), 2'b00, 1'b0); drain();

    // R2: distinct high and low halves, every select combination
    a = '0; b = '0;
    for (int w = 0; w < 16; w++) begin
      a[w*32 +: 32] = {16'(w + 100), 16'(w + 1)};
      b[w*32 +: 32] = {16'(3*w + 7), 16'(2*w + 5)};
    end
    for (int h = 0; h < 4; h++) begin run(a, b, 2'(h), 1'b0); drain(); end

    // R3: negative halfwords
    run(fill(-5, -7), fill(9, -3), 2'b00, 1'b0); drain();
    run(fill(32'hFFF0_0010, 32'h0001_0000), fill(32'h8000_7FFF, 1), 2'b11, 1'b0); drain();

    // R6: accumulate onto the previous result
    run(fill(4, 1), fill(-2, 1), 2'b00, 1'b0); drain();
    run(fill(4, 1), fill(-2, 1), 2'b00, 1'b1); drain();

    // R8: -32768 squared, summed and accumulated well beyond 32 bits
    a = {16{32'h0000_8000}};
    run(a, a, 2'b00, 1'b0); drain();
    run(a, a, 2'b00, 1'b1); drain();
    run(a, a, 2'b00, 1'b1); drain();
    run(fill(1, 0), fill(1, 0), 2'b00, 1'b1); drain();

    // R5: overwrite after accumulation discards history
    run(fill(3, 2), fill(1, 1), 2'b00, 1'b0); drain();

    // R7: restart attempts during busy are ignored
    run(fill(2, 5), fill(7, -1), 2'b01, 1'b0);
    start_i = 1'b1; a_mat_i = fill(99, 9); b_mat_i = fill(11, 4); hsel_i = 2'b11; accum_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    drain();
    repeat (6) @(negedge clk_i);

    // R7: start in the done cycle is accepted (back to back)
    run(fill(6, 1), fill(1, 2), 2'b00, 1'b0);
    repeat (3) @(negedge clk_i);
    run(fill(-1, 3), fill(2, 2), 2'b10, 1'b1);
    drain();

    // Random mix, R1 R2 R6 R10
    for (int t = 0; t < 24; t++) begin
      run(rnd(), rnd(), 2'($urandom), 1'($urandom));
      drain();
    end

    repeat (4) @(negedge clk_i);
    check("R4 queue empty", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule